// File: doc/BRIEF.md
# Dual-Port Lookup RAM Access Unit

This block holds a two-port lookup memory of 512 words of 32 bits, together with the control a small processor core needs to reach it. The local core owns port A. It issues lookup writes, which are stored in a write slot of their own one clock later. It also issues lookup reads. A read stretches the core's two-clock execute by one clock: the address is known only in the first execute clock, and the word arrives at the end of the second. The word is then latched into a holding register, and that register feeds the result path in the third clock.

Port B has two users, and it works without any coupling to port A. A streaming engine may only read through it, using a request, an address and a valid strobe. A neighbouring core may write through it. When both want port B in the same clock, the neighbour's write is served and the streamer's request is dropped for that clock.

Top module: `lut_access_unit`

## Requirements
- R1: A lookup write presented with `wr_start` high in clock t is stored at the clock edge that ends clock t+1. A port A read accepted in clock t+2 or later returns the new word.
- R2: A port A read returns, on `q_data`, the word stored at `rd_addr` as sampled in the clock where the read was accepted.
- R3: In the clock after a read is accepted, `stall` is high, and it stays high for that one clock only.
- R4: `rd_done` is high in the second clock after acceptance, which is the third clock of the read. In that clock `q_data` already carries the read word.
- R5: `rd_start` is accepted only when `stall`, `rd_done` and the pending write slot are all low. At any other time it has no effect.
- R6: `q_data` changes only at the edge that ends a `stall` clock, and it keeps the captured word through later idle clocks.
- R7: A streamer request granted in clock t gives `st_valid` high in clock t+1, with `st_data` equal to the word at `st_addr`.
- R8: If `nb_we` is high in the same clock as `st_req`, the neighbour's word is stored and `st_valid` stays low in the next clock.
- R9: Streamer and neighbour traffic on port B never changes the stall, done or result timing of port A, and port A traffic never changes port B timing.
- R10: If port A's write slot and a port B write hit the same address at the same edge, the port B word is kept.
- R11: A read on one port of an address that the other port writes at the same edge returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Core starts a lookup read (first execute clock) |
| rd_addr | input | ADDR_W | Read word address (S operand) |
| wr_start | input | 1 | Core starts a lookup write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write word |
| stall | output | 1 | Holds the core for one extra clock |
| rd_done | output | 1 | Read result valid on q_data |
| q_data | output | DATA_W | Holding register, kept after the read |
| st_req | input | 1 | Streamer read request |
| st_addr | input | ADDR_W | Streamer read address |
| st_valid | output | 1 | Streamer data valid |
| st_data | output | DATA_W | Streamer read word |
| nb_we | input | 1 | Neighbour core write enable |
| nb_addr | input | ADDR_W | Neighbour write address |
| nb_wdata | input | DATA_W | Neighbour write word |

## Verification
The bench builds the unit with ADDR_W=4 and DATA_W=16. With a 16-entry memory, every address can be filled, read back through the three-clock port A path, rewritten by the neighbour and streamed out, all well within the run length. Expected words come from an arithmetic pattern over address and pass number. The small depth also lets the bench aim same-address collisions and priority contests at chosen entries and then check the whole memory afterwards.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_FETCH = 2'd1,
    RD_DONE  = 2'd2
  } rd_state_t;
endpackage

// File: rtl/lut_ram_dp.sv
module lut_ram_dp #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage: port B is written last, so it wins an address collision.
  // Reads use nonblocking semantics and return the pre-edge contents.
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
    if (b_en && b_we) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
    end else if (a_en && !a_we) begin
      a_rdata <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_rdata <= '0;
    end else if (b_en && !b_we) begin
      b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/lut_porta_ctrl.sv
module lut_porta_ctrl
  import lut_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              stall_o,
  output logic              done_o,
  output logic [DATA_W-1:0] q_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  rd_state_t         state_q;
  logic              wr_pend_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              rd_accept;

  // A read is taken only when the sequencer is idle and the write slot is free.
  assign rd_accept = rd_start_i && (state_q == RD_IDLE) && !wr_pend_q;

  // The write slot is one clock behind the request.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend_q <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_pend_q <= wr_start_i;
      if (wr_start_i) begin
        wr_addr_q <= wr_addr_i;
        wr_data_q <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RD_IDLE;
    end else begin
      unique case (state_q)
        RD_IDLE:  if (rd_accept) state_q <= RD_FETCH;
        RD_FETCH: state_q <= RD_DONE;
        RD_DONE:  state_q <= RD_IDLE;
        default:  state_q <= RD_IDLE;
      endcase
    end
  end

  // The holding register latches the memory word at the end of the stall clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (state_q == RD_FETCH) begin
      q_o <= ram_rdata_i;
    end
  end

  assign stall_o     = (state_q == RD_FETCH);
  assign done_o      = (state_q == RD_DONE);
  assign ram_en_o    = wr_pend_q || rd_accept;
  assign ram_we_o    = wr_pend_q;
  assign ram_addr_o  = wr_pend_q ? wr_addr_q : rd_addr_i;
  assign ram_wdata_o = wr_data_q;

  a_r3_stall_single: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> !stall_o);
  a_r4_done_after_stall: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> done_o);
  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !stall_o);
  a_r6_q_hold: assert property (@(posedge clk) disable iff (rst)
    !stall_o |=> $stable(q_o));
endmodule

// File: rtl/lut_portb_arb.sv
module lut_portb_arb #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_req_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              st_valid_o,
  output logic [DATA_W-1:0] st_data_o,
  input  logic              nb_we_i,
  input  logic [ADDR_W-1:0] nb_addr_i,
  input  logic [DATA_W-1:0] nb_wdata_i,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic st_grant;

  // The neighbour's write always takes the port.
  assign st_grant    = st_req_i && !nb_we_i;
  assign ram_en_o    = nb_we_i || st_grant;
  assign ram_we_o    = nb_we_i;
  assign ram_addr_o  = nb_we_i ? nb_addr_i : st_addr_i;
  assign ram_wdata_o = nb_wdata_i;
  assign st_data_o   = ram_rdata_i;

  always_ff @(posedge clk) begin
    if (rst) st_valid_o <= 1'b0;
    else     st_valid_o <= st_grant;
  end

  a_r8_nb_priority: assert property (@(posedge clk) disable iff (rst)
    nb_we_i |=> !st_valid_o);
  a_r7_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
    st_valid_o |-> $past(st_req_i));
endmodule

// File: rtl/lut_access_unit.sv
module lut_access_unit #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              stall,
  output logic              rd_done,
  output logic [DATA_W-1:0] q_data,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  input  logic              nb_we,
  input  logic [ADDR_W-1:0] nb_addr,
  input  logic [DATA_W-1:0] nb_wdata
);
  logic              a_en, a_we, b_en, b_we;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0] a_wdata, a_rdata, b_wdata, b_rdata;

  lut_porta_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_porta (
    .clk(clk), .rst(rst),
    .rd_start_i(rd_start), .rd_addr_i(rd_addr),
    .wr_start_i(wr_start), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .stall_o(stall), .done_o(rd_done), .q_o(q_data),
    .ram_en_o(a_en), .ram_we_o(a_we), .ram_addr_o(a_addr),
    .ram_wdata_o(a_wdata), .ram_rdata_i(a_rdata)
  );

  lut_portb_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_portb (
    .clk(clk), .rst(rst),
    .st_req_i(st_req), .st_addr_i(st_addr),
    .st_valid_o(st_valid), .st_data_o(st_data),
    .nb_we_i(nb_we), .nb_addr_i(nb_addr), .nb_wdata_i(nb_wdata),
    .ram_en_o(b_en), .ram_we_o(b_we), .ram_addr_o(b_addr),
    .ram_wdata_o(b_wdata), .ram_rdata_i(b_rdata)
  );

  lut_ram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  a_r9_stream_indep: assert property (@(posedge clk) disable iff (rst)
    (stall && st_req && !nb_we) |=> (rd_done && st_valid));
endmodule

// File: tb/tb_lut_access_unit.sv
module tb_lut_access_unit;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_start = 0, wr_start = 0, st_req = 0, nb_we = 0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0, st_addr = '0, nb_addr = '0;
  logic [DW-1:0] wr_data = '0, nb_wdata = '0;
  logic stall, rd_done, st_valid;
  logic [DW-1:0] q_data, st_data;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [N];

  always #2 clk = ~clk;

  lut_access_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .rd_start(rd_start), .rd_addr(rd_addr),
    .wr_start(wr_start), .wr_addr(wr_addr), .wr_data(wr_data),
    .stall(stall), .rd_done(rd_done), .q_data(q_data),
    .st_req(st_req), .st_addr(st_addr), .st_valid(st_valid), .st_data(st_data),
    .nb_we(nb_we), .nb_addr(nb_addr), .nb_wdata(nb_wdata)
  );

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 16'h0123 + s * 16'h1111) ^ 16'h5A5A);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_write(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_start = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_start = 0;
    @(negedge clk);
    model[a] = d;
  endtask

  task automatic a_read(input int a, input string tag);
    @(negedge clk); rd_start = 1; rd_addr = AW'(a);
    @(negedge clk); rd_start = 0;
    check({tag, " R3 stall"}, DW'(stall), 1);
    check({tag, " R4 early done"}, DW'(rd_done), 0);
    @(negedge clk);
    check({tag, " R4 done"}, DW'(rd_done), 1);
    check({tag, " R3 stall off"}, DW'(stall), 0);
    check({tag, " R2 data"}, q_data, model[a]);
    @(negedge clk);
    check({tag, " R4 done one clk"}, DW'(rd_done), 0);
    check({tag, " R6 q held"}, q_data, model[a]);
  endtask

  task automatic s_read(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); st_req = 1; st_addr = AW'(a);
    @(negedge clk); st_req = 0;
    check({tag, " R7 valid"}, DW'(st_valid), 1);
    check({tag, " R7 data"}, st_data, exp);
  endtask

  task automatic n_write(input int a, input logic [DW-1:0] d);
    @(negedge clk); nb_we = 1; nb_addr = AW'(a); nb_wdata = d;
    @(negedge clk); nb_we = 0;
    model[a] = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("reset stall", DW'(stall), 0);
    check("reset done", DW'(rd_done), 0);
    check("reset st_valid", DW'(st_valid), 0);
    check("reset q", q_data, 0);

    // R1: back-to-back port A writes, then read everything through port A
    for (int a = 0; a < N; a++) begin
      @(negedge clk); wr_start = 1; wr_addr = AW'(a); wr_data = pat(a, 0);
      model[a] = pat(a, 0);
    end
    @(negedge clk); wr_start = 0;
    for (int a = 0; a < N; a++) a_read(a, "R1 sweep");

    // R6: q kept over idle clocks
    repeat (5) @(negedge clk);
    check("R6 q after idle", q_data, model[N-1]);

    // R5: rd_start held through stall and done clocks is ignored
    @(negedge clk); rd_start = 1; rd_addr = AW'(3);
    @(negedge clk); rd_addr = AW'(9);
    check("R5 stall", DW'(stall), 1);
    @(negedge clk);
    check("R5 first address", q_data, model[3]);
    @(negedge clk); rd_start = 0;
    check("R5 no restart", DW'(stall), 0);
    // R5: read ignored while the write slot is pending
    @(negedge clk); wr_start = 1; wr_addr = AW'(5); wr_data = pat(5, 1);
    @(negedge clk); wr_start = 0; rd_start = 1; rd_addr = AW'(6);
    @(negedge clk); rd_start = 0;
    check("R5 blocked by write slot", DW'(stall), 0);
    model[5] = pat(5, 1);
    a_read(5, "R1 rewrite");

    // R7: neighbour rewrites all, streamer reads all
    for (int a = 0; a < N; a++) n_write(a, pat(a, 2));
    for (int a = 0; a < N; a++) s_read(a, model[a], "R7 sweep");

    // R8: neighbour write beats streamer request
    @(negedge clk); nb_we = 1; nb_addr = AW'(7); nb_wdata = pat(7, 3);
    st_req = 1; st_addr = AW'(2);
    @(negedge clk); nb_we = 0; st_req = 0;
    check("R8 streamer dropped", DW'(st_valid), 0);
    model[7] = pat(7, 3);
    s_read(7, model[7], "R8 neighbour stored");

    // R9: concurrent port A read and streamer read
    @(negedge clk); rd_start = 1; rd_addr = AW'(4); st_req = 1; st_addr = AW'(11);
    @(negedge clk); rd_start = 0; st_req = 0;
    check("R9 stall", DW'(stall), 1);
    check("R9 st_valid", DW'(st_valid), 1);
    check("R9 st_data", st_data, model[11]);
    @(negedge clk);
    check("R9 done", DW'(rd_done), 1);
    check("R9 q", q_data, model[4]);

    // R10: same address written by both ports at one edge
    @(negedge clk); wr_start = 1; wr_addr = AW'(12); wr_data = pat(12, 4);
    @(negedge clk); wr_start = 0; nb_we = 1; nb_addr = AW'(12); nb_wdata = pat(12, 5);
    @(negedge clk); nb_we = 0;
    model[12] = pat(12, 5);
    a_read(12, "R10 port B wins");

    // R11: streamer reads while port A write slot stores the same address
    @(negedge clk); wr_start = 1; wr_addr = AW'(13); wr_data = pat(13, 6);
    @(negedge clk); wr_start = 0; st_req = 1; st_addr = AW'(13);
    @(negedge clk); st_req = 0;
    check("R11 old data", st_data, model[13]);
    model[13] = pat(13, 6);
    s_read(13, model[13], "R11 new data");

    // final sweep over whole memory through port B
    for (int a = 0; a < N; a++) s_read(a, model[a], "R7 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule